// File: doc/BRIEF.md
# Dual-Clock Almost-Full / Almost-Empty Flag Generator

This block produces two active-low early-warning flags for a FIFO whose write and read sides run on unrelated clocks. The almost-empty flag warns the reader that only a few words remain. The almost-full flag warns the writer that only a few free locations remain. Each threshold is a programmable offset. The block takes the binary write pointer from the write domain and the binary read pointer from the read domain. It moves each pointer into the other domain as Gray code through a register chain, so that each side works out its own cautious view of the fill level.

A timing-select input is captured while master reset is held low. In local timing, each flag is a register in its own domain: almost-full in the write domain and almost-empty in the read domain. In split timing, the clock that observes the condition arising asserts the flag, and the opposite clock releases it. A toggle handshake between the two domains carries the assert and release events, so the flag output never depends on more than one register changing at a time.

Top module: `almost_flag_gen`

## Requirements
- R1: `timing_sel` is captured only while `mrst_n` is low: 1 selects local timing and 0 selects split timing. Changes of `timing_sel` after reset has been released have no effect on flag timing.
- R2: While `mrst_n` is low and in the cycles right after its release with the FIFO empty, `ae_n` is 0 (asserted) and `af_n` is 1 (deasserted).
- R3: Once the pointers have been stable long enough to settle, `ae_n` is 0 exactly when the stored word count, (wr_ptr − rd_ptr) mod 2^(ADDR_W+1), is at most `ae_offset`.
- R4: Once the pointers have settled, `af_n` is 0 exactly when the free count, 2^ADDR_W minus the stored count, is at most `af_offset`.
- R5: In local timing, `af_n` changes only on rising edges of `wclk`.
- R6: In local timing, `ae_n` changes only on rising edges of `rclk`.
- R7: In split timing, `af_n` falls only on a rising `wclk` edge and rises only on a rising `rclk` edge.
- R8: In split timing, `ae_n` falls only on a rising `rclk` edge and rises only on a rising `wclk` edge.
- R9: A change of offset takes effect at the next edge of the clock that asserts that flag: with the pointers settled, raising `af_offset` to meet the free count drives `af_n` low at the next `wclk` rising edge, and raising `ae_offset` to meet the word count drives `ae_n` low at the next `rclk` rising edge.
- R10: The thresholds in R3 and R4 hold when the pointer values have wrapped, including when wr_ptr is numerically below rd_ptr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| mrst_n | input | 1 | Master reset, active low, sampled synchronously by both clocks |
| timing_sel | input | 1 | Flag-timing select, captured during reset (1 local, 0 split) |
| wr_ptr | input | ADDR_W+1 | Binary write pointer, write-clock domain |
| rd_ptr | input | ADDR_W+1 | Binary read pointer, read-clock domain |
| ae_offset | input | ADDR_W | Almost-empty threshold in words |
| af_offset | input | ADDR_W | Almost-full threshold in free locations |
| ae_n | output | 1 | Almost-empty flag, active low |
| af_n | output | 1 | Almost-full flag, active low |

## Verification
In split timing, an assert event from one clock and a release event from the other can fall on the same instant. The fill level walks across every threshold in both directions while the write clock (5 ns) and the read clock (7.3 ns) line up every 365 ns, so both kinds of event meet at coincident edges many times. Each flag transition is time-stamped against the most recent rising edge of each clock. A transition on a coincident edge is accepted for either clock, and any other transition must match the edge that R5 to R8 allow for its direction. After every pointer step the bench also compares the settled level of each flag with a threshold computed from the step count.

// File: rtl/afgen_pkg.sv
`timescale 1ns/100ps
// Package: shared types for the almost-full / almost-empty flag generator.
// Assumes: nothing beyond standard SystemVerilog packing rules.
package afgen_pkg;

    // Flag-timing choice captured while master reset is held.
    typedef enum logic {
        TIMING_SPLIT = 1'b0,
        TIMING_LOCAL = 1'b1
    } flag_timing_e;

    // Threshold results as seen from one clock domain.
    typedef struct packed {
        logic words_low;   // stored words at or below the empty offset
        logic space_low;   // free locations at or below the full offset
    } level_view_t;

endpackage

// File: rtl/afgen_ptr_sync.sv
`timescale 1ns/100ps
// Module: afgen_ptr_sync
// Converts a binary pointer to Gray code in its source domain, registers it,
// and passes it through a chain of destination-domain flops. The output is
// converted back to binary for arithmetic.
// Assumes: the source pointer moves by at most one per source clock, so the
// Gray value changes in one bit at a time. STAGES is at least 2.
module afgen_ptr_sync #(
    parameter int PW     = 5,
    parameter int STAGES = 2
) (
    input  logic          src_clk,
    input  logic          src_rst_n,
    input  logic [PW-1:0] src_bin,
    input  logic          dst_clk,
    input  logic          dst_rst_n,
    output logic [PW-1:0] dst_bin
);

    logic [PW-1:0]             src_gray_q;
    logic [STAGES-1:0][PW-1:0] stage_q;

    // Register the Gray form so that no combinational glitch crosses domains.
    always_ff @(posedge src_clk) begin
        if (!src_rst_n) begin
            src_gray_q <= '0;
        end else begin
            src_gray_q <= src_bin ^ (src_bin >> 1);
        end
    end

    // Shift the Gray value through the destination-domain flop chain.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[STAGES-2:0], src_gray_q};
        end
    end

    // Decode the Gray value back to binary by accumulating XOR from the top bit.
    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = PW - 1; i >= 0; i--) begin
            acc        = acc ^ stage_q[STAGES-1][i];
            dst_bin[i] = acc;
        end
    end

endmodule

// File: rtl/afgen_level.sv
`timescale 1ns/100ps
// Module: afgen_level
// Works out the fill level from one domain's pair of pointers and compares
// it against both offsets.
// Assumes: the pointers carry one extra wrap bit, so the difference modulo
// 2^(AW+1) is the stored word count, which lies in 0..2^AW.
module afgen_level
    import afgen_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic [AW:0]   wr_bin,
    input  logic [AW:0]   rd_bin,
    input  logic [AW-1:0] ae_off,
    input  logic [AW-1:0] af_off,
    output level_view_t   view
);

    localparam int            PW      = AW + 1;
    localparam logic [PW-1:0] DEPTH_V = {1'b1, {AW{1'b0}}};

    logic [PW-1:0] fill;
    logic [PW-1:0] free;

    // Subtract the pointers, derive the free count and compare with both thresholds.
    always_comb begin
        fill           = wr_bin - rd_bin;
        free           = DEPTH_V - fill;
        view.words_low = (fill <= {1'b0, ae_off});
        view.space_low = (free <= {1'b0, af_off});
    end

endmodule

// File: rtl/afgen_split_flag.sv
`timescale 1ns/100ps
// Module: afgen_split_flag
// An active-low flag that one clock asserts and another clock releases.
// Each side owns a toggle bit, and the flag is asserted while the two bits
// differ. Each side sees the other's toggle only through a flop chain, so it
// acts only once its previous event has been acknowledged.
// Assumes: both reset inputs are held low together for several cycles of
// both clocks. INIT_ASSERTED gives the flag state while reset is held.
module afgen_split_flag #(
    parameter bit INIT_ASSERTED = 1'b0,
    parameter int STAGES        = 2
) (
    input  logic set_clk,
    input  logic set_rst_n,
    input  logic set_req,
    input  logic clr_clk,
    input  logic clr_rst_n,
    input  logic clr_req,
    output logic flag_n
);

    logic              set_tog;
    logic              clr_tog;
    logic [STAGES-1:0] clr_seen_q;
    logic [STAGES-1:0] set_seen_q;

    // Assert side: toggle when the condition holds and the flag is known to be released.
    always_ff @(posedge set_clk) begin
        if (!set_rst_n) begin
            set_tog    <= INIT_ASSERTED;
            clr_seen_q <= '0;
        end else begin
            clr_seen_q <= {clr_seen_q[STAGES-2:0], clr_tog};
            if (set_req && (set_tog == clr_seen_q[STAGES-1])) begin
                set_tog <= ~set_tog;
            end
        end
    end

    // Release side: toggle when the release condition holds and the flag is known to be asserted.
    always_ff @(posedge clr_clk) begin
        if (!clr_rst_n) begin
            clr_tog    <= 1'b0;
            set_seen_q <= {STAGES{INIT_ASSERTED}};
        end else begin
            set_seen_q <= {set_seen_q[STAGES-2:0], set_tog};
            if (clr_req && (clr_tog != set_seen_q[STAGES-1])) begin
                clr_tog <= ~clr_tog;
            end
        end
    end

    // The flag is asserted (low) while the two toggles disagree.
    assign flag_n = ~(set_tog ^ clr_tog);

endmodule

// File: rtl/almost_flag_gen.sv
`timescale 1ns/100ps
// Module: almost_flag_gen
// Top of the almost-full / almost-empty flag generator. Each pointer is moved
// into the opposite domain, each domain computes a cautious fill level, and
// both a local-timing register and a split-timing handshake flag are built
// for each output. The timing mode captured during reset picks the one that
// drives the output.
// Assumes: mrst_n is held low for several cycles of both clocks and both
// pointers are zero while it is low. Each pointer moves by at most one per
// cycle of its own clock. The offsets stay below 2^ADDR_W.
module almost_flag_gen
    import afgen_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              mrst_n,
    input  logic              timing_sel,
    input  logic [ADDR_W:0]   wr_ptr,
    input  logic [ADDR_W:0]   rd_ptr,
    input  logic [ADDR_W-1:0] ae_offset,
    input  logic [ADDR_W-1:0] af_offset,
    output logic              ae_n,
    output logic              af_n
);

    localparam int PW = ADDR_W + 1;

    flag_timing_e  mode_w;
    flag_timing_e  mode_r;
    logic [PW-1:0] rd_in_w;
    logic [PW-1:0] wr_in_r;
    level_view_t   w_view;
    level_view_t   r_view;
    logic          af_local_q;
    logic          ae_local_q;
    logic          af_split_n;
    logic          ae_split_n;

    // Capture the timing mode in the write domain while reset is held.
    always_ff @(posedge wclk) begin
        if (!mrst_n) begin
            mode_w <= flag_timing_e'(timing_sel);
        end
    end

    // Capture the timing mode in the read domain while reset is held.
    always_ff @(posedge rclk) begin
        if (!mrst_n) begin
            mode_r <= flag_timing_e'(timing_sel);
        end
    end

    afgen_ptr_sync #(
        .PW     (PW),
        .STAGES (SYNC_STAGES)
    ) u_rd_to_w (
        .src_clk   (rclk),
        .src_rst_n (mrst_n),
        .src_bin   (rd_ptr),
        .dst_clk   (wclk),
        .dst_rst_n (mrst_n),
        .dst_bin   (rd_in_w)
    );

    afgen_ptr_sync #(
        .PW     (PW),
        .STAGES (SYNC_STAGES)
    ) u_wr_to_r (
        .src_clk   (wclk),
        .src_rst_n (mrst_n),
        .src_bin   (wr_ptr),
        .dst_clk   (rclk),
        .dst_rst_n (mrst_n),
        .dst_bin   (wr_in_r)
    );

    afgen_level #(
        .AW (ADDR_W)
    ) u_level_w (
        .wr_bin (wr_ptr),
        .rd_bin (rd_in_w),
        .ae_off (ae_offset),
        .af_off (af_offset),
        .view   (w_view)
    );

    afgen_level #(
        .AW (ADDR_W)
    ) u_level_r (
        .wr_bin (wr_in_r),
        .rd_bin (rd_ptr),
        .ae_off (ae_offset),
        .af_off (af_offset),
        .view   (r_view)
    );

    // Local-timing almost-full: follows the write-domain view on each write edge.
    always_ff @(posedge wclk) begin
        if (!mrst_n) begin
            af_local_q <= 1'b1;
        end else begin
            af_local_q <= ~w_view.space_low;
        end
    end

    // Local-timing almost-empty: follows the read-domain view on each read edge.
    always_ff @(posedge rclk) begin
        if (!mrst_n) begin
            ae_local_q <= 1'b0;
        end else begin
            ae_local_q <= ~r_view.words_low;
        end
    end

    afgen_split_flag #(
        .INIT_ASSERTED (1'b0),
        .STAGES        (SYNC_STAGES)
    ) u_af_split (
        .set_clk   (wclk),
        .set_rst_n (mrst_n),
        .set_req   (w_view.space_low),
        .clr_clk   (rclk),
        .clr_rst_n (mrst_n),
        .clr_req   (~r_view.space_low),
        .flag_n    (af_split_n)
    );

    afgen_split_flag #(
        .INIT_ASSERTED (1'b1),
        .STAGES        (SYNC_STAGES)
    ) u_ae_split (
        .set_clk   (rclk),
        .set_rst_n (mrst_n),
        .set_req   (r_view.words_low),
        .clr_clk   (wclk),
        .clr_rst_n (mrst_n),
        .clr_req   (~w_view.words_low),
        .flag_n    (ae_split_n)
    );

    // Select each output by the mode held in the domain that asserts it.
    assign af_n = (mode_w == TIMING_LOCAL) ? af_local_q : af_split_n;
    assign ae_n = (mode_r == TIMING_LOCAL) ? ae_local_q : ae_split_n;

endmodule

// File: rtl/afgen_checks.sv
`timescale 1ns/100ps
// Module: afgen_checks
// Temporal properties of the flag generator, bound into almost_flag_gen.
// Assumes: the same reset discipline as the design.
module afgen_checks (
    input logic wclk,
    input logic rclk,
    input logic mrst_n,
    input logic mode_w,
    input logic mode_r,
    input logic ae_n,
    input logic af_n,
    input logic w_words_low,
    input logic w_space_low,
    input logic r_words_low,
    input logic r_space_low
);

    // R1
    mode_hold_w_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
        $past(mrst_n) |-> $stable(mode_w));

    // R1
    mode_hold_r_chk: assert property (@(posedge rclk) disable iff (!mrst_n)
        $past(mrst_n) |-> $stable(mode_r));

    // R2
    reset_af_chk: assert property (@(posedge wclk)
        (!mrst_n && !$past(mrst_n)) |=> af_n);

    // R2
    reset_ae_chk: assert property (@(posedge rclk)
        (!mrst_n && !$past(mrst_n)) |=> !ae_n);

    // R5
    local_af_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
        (mode_w && !$stable(af_n)) |-> (af_n == !$past(w_space_low)));

    // R6
    local_ae_chk: assert property (@(posedge rclk) disable iff (!mrst_n)
        (mode_r && !$stable(ae_n)) |-> (ae_n == !$past(r_words_low)));

    // R7
    split_af_fall_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
        (!mode_w && $fell(af_n)) |-> $past(w_space_low));

    // R7
    split_af_rise_chk: assert property (@(posedge rclk) disable iff (!mrst_n)
        (!mode_r && $rose(af_n)) |-> !$past(r_space_low));

    // R8
    split_ae_fall_chk: assert property (@(posedge rclk) disable iff (!mrst_n)
        (!mode_r && $fell(ae_n)) |-> $past(r_words_low));

    // R8
    split_ae_rise_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
        (!mode_w && $rose(ae_n)) |-> !$past(w_words_low));

endmodule

bind almost_flag_gen afgen_checks i_flag_chk (
    .wclk        (wclk),
    .rclk        (rclk),
    .mrst_n      (mrst_n),
    .mode_w      (mode_w),
    .mode_r      (mode_r),
    .ae_n        (ae_n),
    .af_n        (af_n),
    .w_words_low (w_view.words_low),
    .w_space_low (w_view.space_low),
    .r_words_low (r_view.words_low),
    .r_space_low (r_view.space_low)
);

// File: tb/test_almost_flag_gen.sv
`timescale 1ns/100ps
// Bench: sweeps every offset pair of an 8-deep configuration through the full
// fill range in both timing modes, time-stamps every flag transition against
// the clock edges, and probes offset changes at the edge that must act on them.
module test_almost_flag_gen;

    localparam int AW    = 3;
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic          wclk       = 1'b0;
    logic          rclk       = 1'b0;
    logic          mrst_n     = 1'b0;
    logic          timing_sel = 1'b1;
    logic [PW-1:0] wr_ptr     = '0;
    logic [PW-1:0] rd_ptr     = '0;
    logic [AW-1:0] ae_offset  = '0;
    logic [AW-1:0] af_offset  = '0;
    logic          ae_n;
    logic          af_n;

    int      checks   = 0;
    int      errors   = 0;
    bit      done     = 1'b0;
    bit      mon_en   = 1'b0;
    bit      mode_lat = 1'b1;
    realtime t_w      = -1.0;
    realtime t_r      = -1.0;

    almost_flag_gen #(
        .ADDR_W      (AW),
        .SYNC_STAGES (2)
    ) i_almost_flag_gen (
        .wclk       (wclk),
        .rclk       (rclk),
        .mrst_n     (mrst_n),
        .timing_sel (timing_sel),
        .wr_ptr     (wr_ptr),
        .rd_ptr     (rd_ptr),
        .ae_offset  (ae_offset),
        .af_offset  (af_offset),
        .ae_n       (ae_n),
        .af_n       (af_n)
    );

    always #2.5  wclk = ~wclk;
    always #3.65 rclk = ~rclk;

    always @(posedge wclk) t_w = $realtime;
    always @(posedge rclk) t_r = $realtime;

    task automatic chk(input bit ok, input string tag, input real act, input real exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0g expected=%0g at %0t", tag, act, exp, $realtime);
        end
    endtask

    // Edge monitor for the almost-full flag (R5, R7; R1 via the latched mode).
    always @(af_n) begin
        if (mon_en) begin
            if (mode_lat)
                chk(t_w == $realtime, "R1/R5 af_n moved off a wclk edge (time of last wclk)", t_w, $realtime);
            else if (af_n == 1'b0)
                chk(t_w == $realtime, "R7 af_n fell off a wclk edge (time of last wclk)", t_w, $realtime);
            else
                chk(t_r == $realtime, "R7 af_n rose off an rclk edge (time of last rclk)", t_r, $realtime);
        end
    end

    // Edge monitor for the almost-empty flag (R6, R8; R1 via the latched mode).
    always @(ae_n) begin
        if (mon_en) begin
            if (mode_lat)
                chk(t_r == $realtime, "R1/R6 ae_n moved off an rclk edge (time of last rclk)", t_r, $realtime);
            else if (ae_n == 1'b0)
                chk(t_r == $realtime, "R8 ae_n fell off an rclk edge (time of last rclk)", t_r, $realtime);
            else
                chk(t_w == $realtime, "R8 ae_n rose off a wclk edge (time of last wclk)", t_w, $realtime);
        end
    end

    task automatic push();
        @(negedge wclk) wr_ptr = wr_ptr + 1'b1;
    endtask

    task automatic pop();
        @(negedge rclk) rd_ptr = rd_ptr + 1'b1;
    endtask

    task automatic settle();
        repeat (10) @(negedge rclk);
        @(negedge wclk);
    endtask

    // Level check against thresholds computed from the bench's own fill count (R3, R4, R10).
    task automatic expect_levels(input int fill, input int n, input int m);
        bit exp_ae;
        bit exp_af;
        exp_ae = (fill <= n) ? 1'b0 : 1'b1;
        exp_af = ((DEPTH - fill) <= m) ? 1'b0 : 1'b1;
        if (wr_ptr < rd_ptr) begin
            chk(ae_n == exp_ae, "R10 ae_n level with wrapped pointers", ae_n, exp_ae);
            chk(af_n == exp_af, "R10 af_n level with wrapped pointers", af_n, exp_af);
        end else begin
            chk(ae_n == exp_ae, "R3 ae_n level", ae_n, exp_ae);
            chk(af_n == exp_af, "R4 af_n level", af_n, exp_af);
        end
    endtask

    // Reset into a mode, check the reset state, then move timing_sel away (R1, R2).
    task automatic do_reset(input bit mode);
        mon_en = 1'b0;
        @(negedge wclk);
        mrst_n     = 1'b0;
        timing_sel = mode;
        mode_lat   = mode;
        wr_ptr     = '0;
        rd_ptr     = '0;
        repeat (4) @(negedge rclk);
        chk(ae_n == 1'b0, "R2 ae_n during reset", ae_n, 0);
        chk(af_n == 1'b1, "R2 af_n during reset", af_n, 1);
        @(negedge wclk);
        mrst_n = 1'b1;
        timing_sel = ~mode;
        repeat (2) @(negedge rclk);
        mon_en = 1'b1;
        @(negedge wclk);
        chk(ae_n == 1'b0, "R2 ae_n after release", ae_n, 0);
        chk(af_n == 1'b1, "R2 af_n after release", af_n, 1);
    endtask

    // Full sweep: every offset pair, fill walked up to full and back to empty.
    task automatic sweep();
        for (int n = 0; n < DEPTH; n++) begin
            for (int m = 0; m < DEPTH; m++) begin
                @(negedge wclk);
                ae_offset = AW'(n);
                af_offset = AW'(m);
                settle();
                expect_levels(0, n, m);
                for (int k = 1; k <= DEPTH; k++) begin
                    push();
                    settle();
                    expect_levels(k, n, m);
                end
                for (int k = DEPTH - 1; k >= 0; k--) begin
                    pop();
                    settle();
                    expect_levels(k, n, m);
                end
            end
        end
    endtask

    // Offset changes act at the next edge of the asserting clock (R9).
    task automatic offset_probe();
        @(negedge wclk);
        ae_offset = 3'd3;
        af_offset = 3'd3;
        for (int k = 0; k < 4; k++) push();
        settle();
        chk(ae_n == 1'b1, "R9 ae_n before offset raise", ae_n, 1);
        chk(af_n == 1'b1, "R9 af_n before offset raise", af_n, 1);
        @(negedge wclk) af_offset = 3'd4;
        @(posedge wclk) #1;
        chk(af_n == 1'b0, "R9 af_n one wclk edge after offset raise", af_n, 0);
        @(negedge rclk) ae_offset = 3'd4;
        @(posedge rclk) #1;
        chk(ae_n == 1'b0, "R9 ae_n one rclk edge after offset raise", ae_n, 0);
        @(negedge wclk);
        ae_offset = 3'd3;
        af_offset = 3'd3;
        settle();
        chk(ae_n == 1'b1, "R9 ae_n after offset lowered", ae_n, 1);
        chk(af_n == 1'b1, "R9 af_n after offset lowered", af_n, 1);
        for (int k = 0; k < 4; k++) pop();
        settle();
    endtask

    initial begin
        do_reset(1'b1);
        sweep();
        offset_probe();
        do_reset(1'b0);
        sweep();
        offset_probe();
        mon_en = 1'b0;
        done   = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #900000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule